// File: doc/BRIEF.md
# Dual-Ratio Clock Divider with Coincidence Strobe

The block takes one fast clock and derives two slower clocks from it, bank A and bank C. Each bank divides by its own even ratio, chosen by a 3-bit select. Because the two ratios can differ, the two outputs rise together only once per common period. That period is the least common multiple of the two ratios, counted in fast-clock cycles. An active-low strobe goes low ahead of each such common rising edge. Downstream logic uses the strobe to line up transfers between the two derived domains. It works for integer ratios such as 2:1 and also for non-integer ones such as 3:2 and 4:3.

All timing comes from counters in the fast clock domain, and every output is taken directly from a flip-flop. The selects are read once, on the first fast-clock edge after reset is released. After that they are ignored until the next reset, so a select change can never produce a false strobe.

Top module: `dual_div_sync`

## Requirements
- R1: A select code maps to a divide ratio as follows: 0 gives 2, 1 gives 4, 2 gives 6, 3 gives 8, and any code from 4 to 7 gives 12.
- R2: Each divided clock runs at its ratio N with a 50 % duty cycle. It is high for N/2 fast cycles starting at its rising edge, then low for N/2 fast cycles.
- R3: While reset is low, and until the first rising fast-clock edge after reset is released, both divided clocks are low and the strobe is high.
- R4: On that first fast-clock edge after release, both divided clocks rise together.
- R5: The selects are sampled only on that first edge. Later changes have no effect on any output until reset has been asserted and released again.
- R6: The strobe is low for exactly min(Na, Nc) fast cycles, where Na and Nc are the two ratios. Those cycles end at an edge where both divided clocks rise. At all other times the strobe is high.
- R7: Both divided clocks rise together every L fast cycles, where L is the least common multiple of Na and Nc. The strobe pattern repeats with period L.
- R8: When both banks use the same ratio, the strobe stays low from the first edge after release onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_a_i | input | 3 | Bank A ratio select |
| sel_c_i | input | 3 | Bank C ratio select |
| clk_a_o | output | 1 | Bank A divided clock |
| clk_c_o | output | 1 | Bank C divided clock |
| sync_no | output | 1 | Active-low coincidence strobe |

## Verification
The bench applies ratio pairs with non-integer relations (3:2, 4:3), pairs where the slower clock is on either bank, and equal ratios. A design that sized the strobe from bank A alone would give a pulse of the wrong width whenever bank C is faster. A design that wrapped its common counter at the product of the ratios instead of their least common multiple would drift off the shared edge for the pairs 4:6, 6:8 and 8:12.

The bench also checks the equal-ratio case, where a design that released the strobe at every wrap would show one-cycle high glitches. It changes the selects while the block is running, which exposes any design that reloads its ratios without a reset. It also checks the first edge after reset, where an off-by-one start would put the two clocks out of phase.

// File: rtl/dsync_pkg.sv
package dsync_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned CNT_W = 5;
  localparam int unsigned MAX_MULT = 12;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [SEL_W-1:0] sel_t;

  function automatic cnt_t sel_to_ratio(input sel_t sel);
    case (sel)
      3'd0:    return cnt_t'(2);
      3'd1:    return cnt_t'(4);
      3'd2:    return cnt_t'(6);
      3'd3:    return cnt_t'(8);
      default: return cnt_t'(12);
    endcase
  endfunction

  // smallest multiple of a that b divides
  function automatic cnt_t ratio_lcm(input cnt_t a, input cnt_t b);
    int unsigned ia;
    int unsigned ib;
    int unsigned res;
    ia  = int'(a);
    ib  = int'(b);
    res = ia * ib;
    for (int k = MAX_MULT; k >= 1; k--) begin
      if (ib != 0 && ((ia * int'(k)) % ib) == 0) res = ia * int'(k);
    end
    return cnt_t'(res);
  endfunction
endpackage

// File: rtl/div_bank.sv
module div_bank #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             clk_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             clk_q;

  always_comb begin
    if (load_i)                           cnt_d = '0;
    else if (cnt_q == ratio_i - 1'b1)     cnt_d = '0;
    else                                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= (cnt_d < (ratio_i >> 1));
    end
  end

  assign cnt_o = cnt_q;
  assign clk_o = clk_q;

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_i);
  p_rise_at_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_q) |-> cnt_q == '0);
endmodule

// File: rtl/sync_gen.sv
module sync_gen #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] width_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sync_no
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_q;

  always_comb begin
    if (load_i)                        cnt_d = '0;
    else if (cnt_q == period_i - 1'b1) cnt_d = '0;
    else                               cnt_d = cnt_q + 1'b1;
  end

  // low across the last faster-clock period of the common period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sync_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= !(cnt_d >= period_i - width_i);
    end
  end

  assign cnt_o   = cnt_q;
  assign sync_no = sync_q;

  p_super_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < period_i);
  p_width_fits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    width_i <= period_i);
endmodule

// File: rtl/dual_div_sync.sv
module dual_div_sync
  import dsync_pkg::*;
#(
  parameter int unsigned SW = dsync_pkg::SEL_W,
  parameter int unsigned CW = dsync_pkg::CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] sel_a_i,
  input  logic [SW-1:0] sel_c_i,
  output logic          clk_a_o,
  output logic          clk_c_o,
  output logic          sync_no
);
  localparam int unsigned NB = 2;

  logic          armed_q;
  logic [SW-1:0] sel_w   [NB];
  logic [CW-1:0] ratio_q [NB];
  logic [CW-1:0] ratio_e [NB];
  logic [CW-1:0] cnt_w   [NB];
  logic [NB-1:0] clk_w;
  logic [CW-1:0] lcm_q, lcm_e, fast_q, fast_e, lcm_n, fast_n, super_cnt;

  assign sel_w[0] = sel_a_i;
  assign sel_w[1] = sel_c_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  for (genvar g = 0; g < NB; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ratio_q[g] <= CW'(2);
      else if (!armed_q) ratio_q[g] <= CW'(sel_to_ratio(sel_t'(sel_w[g])));
    end
    assign ratio_e[g] = armed_q ? ratio_q[g] : CW'(sel_to_ratio(sel_t'(sel_w[g])));

    div_bank #(.CNT_W(CW)) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (!armed_q),
      .ratio_i (ratio_e[g]),
      .cnt_o   (cnt_w[g]),
      .clk_o   (clk_w[g])
    );
  end

  assign lcm_n  = CW'(ratio_lcm(cnt_t'(ratio_e[0]), cnt_t'(ratio_e[1])));
  assign fast_n = (ratio_e[0] < ratio_e[1]) ? ratio_e[0] : ratio_e[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcm_q  <= CW'(2);
      fast_q <= CW'(2);
    end else if (!armed_q) begin
      lcm_q  <= lcm_n;
      fast_q <= fast_n;
    end
  end

  assign lcm_e  = armed_q ? lcm_q  : lcm_n;
  assign fast_e = armed_q ? fast_q : fast_n;

  sync_gen #(.CNT_W(CW)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (!armed_q),
    .period_i (lcm_e),
    .width_i  (fast_e),
    .cnt_o    (super_cnt),
    .sync_no  (sync_no)
  );

  assign clk_a_o = clk_w[0];
  assign clk_c_o = clk_w[1];

  p_idle_before_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (!clk_a_o && !clk_c_o && sync_no));
  p_first_edge_joint_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> (clk_a_o && clk_c_o));
  p_ratio_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(armed_q)) |-> ($stable(ratio_q[0]) && $stable(ratio_q[1])));
  p_release_on_common_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_no) |-> ($rose(clk_a_o) && $rose(clk_c_o)));
  p_wrap_aligned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && super_cnt == '0) |-> (cnt_w[0] == '0 && cnt_w[1] == '0));
  p_equal_stays_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && ratio_q[0] == ratio_q[1]) |-> !sync_no);
endmodule

// File: tb/dual_div_sync_test.sv
module dual_div_sync_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sel_a_i = 3'd0;
  logic [2:0] sel_c_i = 3'd0;
  logic       clk_a_o, clk_c_o, sync_no;

  int n_vec = 0;
  int n_bad = 0;

  localparam int NV = 10;
  // {sel_a, sel_c}: 1:1, 2:1, 3:1, 3:2, 4:1, 4:3, 6:1, 3:2 (code 7), reversed 6:1, 1:1 at 12
  localparam logic [5:0] VEC [NV] = '{
    {3'd1, 3'd1}, {3'd1, 3'd3}, {3'd0, 3'd2}, {3'd1, 3'd2}, {3'd0, 3'd3},
    {3'd2, 3'd3}, {3'd0, 3'd4}, {3'd3, 3'd7}, {3'd5, 3'd0}, {3'd6, 3'd4}
  };

  dual_div_sync uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_a_i (sel_a_i),
    .sel_c_i (sel_c_i),
    .clk_a_o (clk_a_o),
    .clk_c_o (clk_c_o),
    .sync_no (sync_no)
  );

  always #5 clk_i = ~clk_i;

  function automatic int dec(input logic [2:0] s);
    if (s == 3'd0) return 2;
    if (s == 3'd1) return 4;
    if (s == 3'd2) return 6;
    if (s == 3'd3) return 8;
    return 12;
  endfunction

  function automatic int gcd(input int x, input int y);
    int a = x;
    int b = y;
    while (b != 0) begin
      int t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // R3: hold reset, verify idle, then release at a negedge
  task automatic do_reset(input logic [2:0] sa, input logic [2:0] sc);
    @(negedge clk_i);
    rst_ni = 1'b0;
    sel_a_i = sa;
    sel_c_i = sc;
    repeat (2) @(negedge clk_i);
    check(clk_a_o, 1'b0, "R3 clk_a in reset");
    check(clk_c_o, 1'b0, "R3 clk_c in reset");
    check(sync_no, 1'b1, "R3 strobe in reset");
    rst_ni = 1'b1;
    #1;
    check(clk_a_o, 1'b0, "R3 clk_a before first edge");
    check(sync_no, 1'b1, "R3 strobe before first edge");
  endtask

  // compare cycles k0..k1 after the first edge against the model for ratios na, nc
  task automatic run_model(input int na, input int nc, input int k0, input int k1);
    int l = (na * nc) / gcd(na, nc);
    int p = (na < nc) ? na : nc;
    for (int k = k0; k <= k1; k++) begin
      @(negedge clk_i);
      if (k == 0) begin
        check(clk_a_o & clk_c_o, 1'b1, "R4 joint first rise");
      end
      check(clk_a_o, ((k % na) < na / 2), "R1 R2 clk_a");
      check(clk_c_o, ((k % nc) < nc / 2), "R1 R2 clk_c");
      if (na == nc)
        check(sync_no, 1'b0, "R8 equal ratio strobe");
      else if (k >= l)
        check(sync_no, !((k % l) >= l - p), "R7 repeat strobe");
      else
        check(sync_no, !((k % l) >= l - p), "R6 strobe");
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      do_reset(VEC[v][5:3], VEC[v][2:0]);
      run_model(dec(VEC[v][5:3]), dec(VEC[v][2:0]), 0, 60);
    end

    // R5: change selects while running; outputs keep the old ratios
    do_reset(3'd1, 3'd2);
    run_model(4, 6, 0, 9);
    sel_a_i = 3'd4;
    sel_c_i = 3'd0;
    run_model(4, 6, 10, 50);

    // R5: after a fresh reset the new selects apply
    do_reset(3'd4, 3'd0);
    run_model(12, 2, 0, 40);

    // R6: pulse width counted directly for 6:8 pair (expect 6 low cycles)
    do_reset(3'd2, 3'd3);
    begin
      int low = 0;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk_i);
        if (!sync_no) low++;
      end
      check(low == 6, 1'b1, "R6 strobe width 6 of 24");
    end

    finish_run();
  end
endmodule